// File: doc/BRIEF.md
# Queued-Operation SPI Sequencer

This block is a single-lane SPI master that software drives through a small memory-mapped register window. Software does not write a shift register directly. Every action is described by an operation word holding a 5-bit operation code and a 9-bit byte count. That includes raising or lowering chip select, shifting bytes out and shifting bytes in. Software stages each word, then commits it into a four-entry operation queue. A whole transaction is therefore a chain of queued operations: chip select low, the command byte, the address bytes, the dummy bytes (sent as 0xFF), the data, and chip select high.

Outgoing bytes come from a 16-byte transmit queue. Incoming bytes land in a 16-byte receive queue, which software drains one byte at a time. The sequencer takes operations only while manual operation is enabled, and it runs them strictly in queue order. A shift operation waits when it has no byte to send or no room for a received byte; no bit is lost while it waits. The operation-empty flag rises only once the last operation has fully finished, so software can poll it to learn that the transaction is done.

The sequencer FSM has six states:
- IDLE (code 0): waiting for work. It goes to DISPATCH when manual operation is on and an operation is queued; that operation is popped on the same edge.
- DISPATCH: applies a chip-select operation and returns to IDLE. For a shift code with a nonzero count it goes to TX_WAIT or RX_WAIT. For any other code, or a count of zero, it returns to IDLE.
- TX_WAIT: goes to SHIFT, loading the next transmit byte, once the transmit queue is non-empty.
- RX_WAIT: goes to SHIFT once the receive queue has room.
- SHIFT: runs eight SCK periods and moves to BYTE_END on the eighth falling edge.
- BYTE_END: counts the byte down and stores a received byte. It returns to IDLE after the last byte, and otherwise goes back to TX_WAIT or RX_WAIT.

Top module: `spi_op_seq`

## Requirements
- R1: After reset, chip select is high and SCK is low. The register reads are: operation queue empty (0x24 bit 0) = 1, operation queue full (0x2C) = 0, transmit full (0x34) = 0, receive empty (0x3C) = 1, manual enable (0x20) = 0, sequencer state (0x18) = 0.
- R2: Writes to 0x28 stage an operation word, byte count in bits [8:0] and code in bits [13:9]; 0x28 reads the staged word back. Writing 1 to bit 0 of 0x30 commits the staged word. 0x2C bit 0 reads 1 when four words are queued, and a commit made while the queue is full is dropped.
- R3: No operation is taken while manual enable (0x20 bit 0) is 0. The 4-bit sequencer state at 0x18 reads 0 only while the sequencer is idle.
- R4: Code 0 drives chip select high. Code 1 drives chip select low.
- R5: Code 0x08 sends the counted bytes from the transmit queue on MOSI, MSB first. MOSI changes while SCK is low, and the device samples it on the SCK rising edge (mode 0).
- R6: Code 0x0C samples MISO on each SCK rising edge, MSB first, and stores the counted bytes in the receive queue. 0x44 shows the head byte, and writing 1 to bit 0 of 0x40 advances to the next byte.
- R7: A transmit operation holds with SCK low while the transmit queue is empty. It resumes when bytes are written, and no byte is skipped.
- R8: A receive operation holds while the receive queue is full, and no bit is dropped. An 18-byte receive into the 16-byte queue delivers all 18 bytes in order.
- R9: Operations run strictly in the order they were committed.
- R10: The operation queue empty flag reads 1 only when no operation is queued and the sequencer has finished the last one.
- R11: An undefined code, or a shift code with count 0, is consumed without any SCK activity and without changing chip select.
- R12: 0x38 bits [7:0] push a transmit byte. 0x34 bit 0 reads 1 when 16 bytes are held, and a byte written while the queue is full is discarded.
- R13: SCK idles low while the sequencer is idle. Each SCK high phase lasts exactly HALF_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 14 | Register write data |
| reg_rdata | output | 14 | Register read data, combinational from reg_addr |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Software relies on the operation-empty flag to mean "done", so a sequencer stuck in the wrong state would show at the ports as one of two things. Either that flag never rises, or SCK pulses start or stop at the wrong time, within one byte time of the fault. A wrong count or a lost bit in the shifter shows up as a byte at the slave model, or a byte read back from 0x44, that differs from the reference queue at the end of the operation. A wrong queue pointer or depth shows up at the full flags, or as a dropped commit that changes the final chip-select level.

// File: rtl/spi_op_pkg.sv
package spi_op_pkg;
    localparam int LEN_W  = 9;
    localparam int CODE_W = 5;
    localparam int OPW_W  = LEN_W + CODE_W;
    localparam int REG_DW = OPW_W;

    localparam logic [CODE_W-1:0] OP_CS_HIGH = 5'h00;
    localparam logic [CODE_W-1:0] OP_CS_LOW  = 5'h01;
    localparam logic [CODE_W-1:0] OP_TX      = 5'h08;
    localparam logic [CODE_W-1:0] OP_RX      = 5'h0C;

    localparam logic [7:0] A_STATE    = 8'h18;
    localparam logic [7:0] A_MANUAL   = 8'h20;
    localparam logic [7:0] A_OP_EMPTY = 8'h24;
    localparam logic [7:0] A_OP_STAGE = 8'h28;
    localparam logic [7:0] A_OP_FULL  = 8'h2C;
    localparam logic [7:0] A_OP_PUSH  = 8'h30;
    localparam logic [7:0] A_TX_FULL  = 8'h34;
    localparam logic [7:0] A_TX_DATA  = 8'h38;
    localparam logic [7:0] A_RX_EMPTY = 8'h3C;
    localparam logic [7:0] A_RX_POP   = 8'h40;
    localparam logic [7:0] A_RX_HEAD  = 8'h44;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_DISPATCH = 4'd1,
        ST_TX_WAIT  = 4'd2,
        ST_RX_WAIT  = 4'd3,
        ST_SHIFT    = 4'd4,
        ST_BYTE_END = 4'd5
    } seq_state_e;
endpackage

// File: rtl/spi_op_fifo.sv
module spi_op_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spi_op_engine.sv
module spi_op_engine
    import spi_op_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             op_empty,
    input  logic [OPW_W-1:0] op_word,
    output logic             op_pop,
    input  logic             tx_empty,
    input  logic [7:0]       tx_byte,
    output logic             tx_pop,
    input  logic             rx_full,
    output logic             rx_push,
    output logic [7:0]       rx_byte,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso,
    output logic             busy,
    output logic [3:0]       state_code
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    seq_state_e        state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic [LEN_W-1:0]  len_q;
    logic              is_rx_q, cs_n_q, sck_q;
    logic [2:0]        bit_q;
    logic [DIV_W-1:0]  div_q;
    logic [7:0]        tx_sh_q, rx_sh_q;
    logic              tick;

    assign tick = (div_q == DIV_W'(HALF_DIV - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (run_en && !op_empty) state_d = ST_DISPATCH;
            ST_DISPATCH: begin
                if (code_q == OP_TX && len_q != '0)      state_d = ST_TX_WAIT;
                else if (code_q == OP_RX && len_q != '0) state_d = ST_RX_WAIT;
                else                                     state_d = ST_IDLE;
            end
            ST_TX_WAIT:
                if (!tx_empty) state_d = ST_SHIFT;
            ST_RX_WAIT:
                if (!rx_full) state_d = ST_SHIFT;
            ST_SHIFT:
                if (tick && sck_q && bit_q == 3'd7) state_d = ST_BYTE_END;
            ST_BYTE_END: begin
                if (len_q == LEN_W'(1)) state_d = ST_IDLE;
                else if (is_rx_q)       state_d = ST_RX_WAIT;
                else                    state_d = ST_TX_WAIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    assign op_pop     = (state_q == ST_IDLE) && run_en && !op_empty;
    assign tx_pop     = (state_q == ST_TX_WAIT) && !tx_empty;
    assign rx_push    = (state_q == ST_BYTE_END) && is_rx_q;
    assign rx_byte    = rx_sh_q;
    assign busy       = (state_q != ST_IDLE);
    assign state_code = state_q;
    assign sck        = sck_q;
    assign cs_n       = cs_n_q;
    assign mosi       = tx_sh_q[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= '0;
            len_q   <= '0;
            is_rx_q <= 1'b0;
            cs_n_q  <= 1'b1;
            sck_q   <= 1'b0;
            bit_q   <= '0;
            div_q   <= '0;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (op_pop) begin
                        code_q  <= op_word[OPW_W-1:LEN_W];
                        len_q   <= op_word[LEN_W-1:0];
                        is_rx_q <= (op_word[OPW_W-1:LEN_W] == OP_RX);
                    end
                end
                ST_DISPATCH: begin
                    if (code_q == OP_CS_HIGH)     cs_n_q <= 1'b1;
                    else if (code_q == OP_CS_LOW) cs_n_q <= 1'b0;
                end
                ST_TX_WAIT: begin
                    if (!tx_empty) begin
                        tx_sh_q <= tx_byte;
                        bit_q   <= '0;
                        div_q   <= '0;
                    end
                end
                ST_RX_WAIT: begin
                    if (!rx_full) begin
                        tx_sh_q <= 8'hFF;
                        bit_q   <= '0;
                        div_q   <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        div_q <= '0;
                        if (!sck_q) begin
                            sck_q   <= 1'b1;
                            rx_sh_q <= {rx_sh_q[6:0], miso};
                        end else begin
                            sck_q   <= 1'b0;
                            tx_sh_q <= {tx_sh_q[6:0], 1'b0};
                            bit_q   <= bit_q + 1'b1;
                        end
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                ST_BYTE_END: len_q <= len_q - 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spi_op_seq.sv
module spi_op_seq
    import spi_op_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int OP_DEPTH = 4,
    parameter int DQ_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic [OPW_W-1:0] op_stage_q, op_head;
    logic             manual_en;
    logic             op_push, op_pop, op_full, op_fifo_empty, op_empty_flag;
    logic             tx_push, tx_pop, tx_full, tx_empty;
    logic             rx_push, rx_pop, rx_full, rx_empty;
    logic [7:0]       tx_head, rx_head, rx_byte;
    logic             eng_busy;
    logic [3:0]       state_code;

    assign op_push = reg_wr && reg_addr == A_OP_PUSH && reg_wdata[0];
    assign tx_push = reg_wr && reg_addr == A_TX_DATA;
    assign rx_pop  = reg_wr && reg_addr == A_RX_POP && reg_wdata[0];
    assign op_empty_flag = op_fifo_empty && !eng_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_stage_q <= '0;
            manual_en  <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == A_OP_STAGE) op_stage_q <= reg_wdata[OPW_W-1:0];
            if (reg_addr == A_MANUAL)   manual_en  <= reg_wdata[0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_STATE:    reg_rdata[3:0] = state_code;
            A_MANUAL:   reg_rdata[0]   = manual_en;
            A_OP_EMPTY: reg_rdata[0]   = op_empty_flag;
            A_OP_STAGE: reg_rdata      = op_stage_q;
            A_OP_FULL:  reg_rdata[0]   = op_full;
            A_TX_FULL:  reg_rdata[0]   = tx_full;
            A_RX_EMPTY: reg_rdata[0]   = rx_empty;
            A_RX_HEAD:  reg_rdata[7:0] = rx_head;
            default:    reg_rdata      = '0;
        endcase
    end

    spi_op_fifo #(.WIDTH(OPW_W), .DEPTH(OP_DEPTH)) u_op_q (
        .clk(clk), .rst_n(rst_n), .push(op_push), .din(op_stage_q),
        .pop(op_pop), .dout(op_head), .full(op_full), .empty(op_fifo_empty)
    );

    spi_op_fifo #(.WIDTH(8), .DEPTH(DQ_DEPTH)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(reg_wdata[7:0]),
        .pop(tx_pop), .dout(tx_head), .full(tx_full), .empty(tx_empty)
    );

    spi_op_fifo #(.WIDTH(8), .DEPTH(DQ_DEPTH)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .dout(rx_head), .full(rx_full), .empty(rx_empty)
    );

    spi_op_engine #(.HALF_DIV(HALF_DIV)) u_engine (
        .clk(clk), .rst_n(rst_n), .run_en(manual_en),
        .op_empty(op_fifo_empty), .op_word(op_head), .op_pop(op_pop),
        .tx_empty(tx_empty), .tx_byte(tx_head), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_byte(rx_byte),
        .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso),
        .busy(eng_busy), .state_code(state_code)
    );
endmodule

// File: rtl/spi_op_seq_chk.sv
module spi_op_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       manual_en,
    input logic       eng_busy,
    input logic       op_pop,
    input logic       op_empty_flag,
    input logic       tx_pop,
    input logic       tx_empty,
    input logic       rx_push,
    input logic       rx_full,
    input logic       spi_sck,
    input logic       spi_cs_n,
    input logic [3:0] state_code
);
    p_sck_idle_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !spi_sck);

    p_cs_steady_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |=> $stable(spi_cs_n));

    p_empty_means_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_empty_flag |-> (state_code == 4'd0));

    p_no_tx_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

    p_no_rx_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);

    p_manual_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_pop |-> manual_en);
endmodule

bind spi_op_seq spi_op_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .manual_en(manual_en), .eng_busy(eng_busy),
    .op_pop(op_pop), .op_empty_flag(op_empty_flag), .tx_pop(tx_pop),
    .tx_empty(tx_empty), .rx_push(rx_push), .rx_full(rx_full),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .state_code(state_code)
);

// File: tb/spi_op_seq_bench.sv
module spi_op_seq_bench;
    localparam int HALF = 2;
    localparam int WD   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [13:0] reg_wdata = '0;
    logic [13:0] reg_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int hi_cnt = 0;

    // slave model
    logic [7:0] mosi_cap[$];
    logic [7:0] mosi_acc = '0;
    int         mosi_nb = 0;
    logic [7:0] miso_src[$];
    logic [7:0] miso_cur = 8'hFF;
    int         miso_bit = 0;

    always #2 clk = ~clk;

    spi_op_seq #(.HALF_DIV(HALF)) u_spi_op_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    assign spi_miso = miso_cur[3'(7 - miso_bit)];

    task automatic check(input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge spi_sck) begin
        mosi_acc = {mosi_acc[6:0], spi_mosi};
        mosi_nb++;
        if (mosi_nb == 8) begin
            mosi_cap.push_back(mosi_acc);
            mosi_nb = 0;
        end
        miso_bit++;
        if (miso_bit == 8) begin
            miso_bit = 0;
            miso_cur = (miso_src.size() > 0) ? miso_src.pop_front() : 8'hFF;
        end
    end

    // per-clock reference: SCK high phase length and idle level (R13)
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (spi_sck) hi_cnt++;
            else if (hi_cnt != 0) begin
                check("R13 sck high phase", hi_cnt, HALF);
                hi_cnt = 0;
            end
        end
        if (cyc == WD) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WD);
            summary();
        end
    end

    task automatic reg_write(input logic [7:0] a, input logic [13:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [13:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push_op(input logic [4:0] code, input logic [8:0] len);
        reg_write(8'h28, {code, len});
        reg_write(8'h30, 14'd1);
    endtask

    task automatic wait_done();
        logic [13:0] v;
        do reg_read(8'h24, v); while (v[0] !== 1'b1);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [13:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        reg_read(8'h24, v); check("R1 op empty", v, 1);
        reg_read(8'h2C, v); check("R1 op full", v, 0);
        reg_read(8'h34, v); check("R1 tx full", v, 0);
        reg_read(8'h3C, v); check("R1 rx empty", v, 1);
        reg_read(8'h20, v); check("R1 manual", v, 0);
        reg_read(8'h18, v); check("R1 state", v, 0);
        check("R1 cs_n", spi_cs_n, 1);
        check("R1 sck", spi_sck, 0);

        // R3 gating, R4 chip select low
        push_op(5'h01, 9'd1);
        idle(10);
        check("R3 cs held while disabled", spi_cs_n, 1);
        reg_read(8'h24, v); check("R3 op still queued", v, 0);
        reg_write(8'h20, 14'd1);
        wait_done();
        check("R4 cs low", spi_cs_n, 0);
        reg_read(8'h18, v); check("R3 state idle zero", v, 0);

        // R5 transmit with dummy byte
        mosi_cap.delete();
        reg_write(8'h38, 14'hA5); reg_write(8'h38, 14'h3C); reg_write(8'h38, 14'hFF);
        push_op(5'h08, 9'd3);
        wait_done();
        check("R5 tx count", mosi_cap.size(), 3);
        check("R5 byte0", mosi_cap[0], 8'hA5);
        check("R5 byte1", mosi_cap[1], 8'h3C);
        check("R5 byte2", mosi_cap[2], 8'hFF);

        // R6 receive
        miso_bit = 0; miso_cur = 8'h5A; miso_src.delete(); miso_src.push_back(8'hC3);
        push_op(5'h0C, 9'd2);
        wait_done();
        reg_read(8'h3C, v); check("R6 rx not empty", v, 0);
        reg_read(8'h44, v); check("R6 head0", v, 8'h5A);
        reg_write(8'h40, 14'd1);
        reg_read(8'h44, v); check("R6 head1", v, 8'hC3);
        reg_write(8'h40, 14'd1);
        reg_read(8'h3C, v); check("R6 rx drained", v, 1);

        // R8 receive stall with 18 bytes into 16-deep queue
        miso_bit = 0; miso_cur = 8'd1; miso_src.delete();
        for (int i = 1; i < 18; i++) miso_src.push_back(8'(i * 7 + 1));
        push_op(5'h0C, 9'd18);
        idle(1000);
        reg_read(8'h24, v); check("R10 empty low while stalled", v, 0);
        reg_read(8'h18, v); check("R3 state nonzero while busy", (v != 0), 1);
        for (int i = 0; i < 18; i++) begin
            do reg_read(8'h3C, v); while (v[0]);
            reg_read(8'h44, v); check("R8 rx byte", v, (i * 7 + 1) & 8'hFF);
            reg_write(8'h40, 14'd1);
        end
        wait_done();

        // R7 transmit stall on empty queue
        mosi_cap.delete();
        push_op(5'h08, 9'd2);
        idle(100);
        check("R7 no bytes while starved", mosi_cap.size(), 0);
        check("R7 sck low while starved", spi_sck, 0);
        reg_read(8'h24, v); check("R10 empty low while starved", v, 0);
        reg_write(8'h38, 14'h11); reg_write(8'h38, 14'h22);
        wait_done();
        check("R7 count", mosi_cap.size(), 2);
        check("R7 byte0", mosi_cap[0], 8'h11);
        check("R7 byte1", mosi_cap[1], 8'h22);

        // R2 queue full, dropped commit, R9 order
        reg_write(8'h20, 14'd0);
        push_op(5'h00, 9'd1); push_op(5'h01, 9'd1);
        push_op(5'h00, 9'd1); push_op(5'h01, 9'd1);
        reg_read(8'h2C, v); check("R2 op full", v, 1);
        push_op(5'h00, 9'd1);
        reg_read(8'h28, v); check("R2 staged readback", v, 14'h001);
        reg_write(8'h20, 14'd1);
        wait_done();
        check("R9 last op wins, fifth dropped", spi_cs_n, 0);
        reg_read(8'h2C, v); check("R2 op not full", v, 0);

        // R11 undefined code and zero length
        mosi_cap.delete();
        push_op(5'h05, 9'd3);
        push_op(5'h08, 9'd0);
        wait_done();
        check("R11 no bytes", mosi_cap.size(), 0);
        check("R11 cs unchanged", spi_cs_n, 0);

        // R12 transmit queue full and drop
        for (int i = 0; i < 16; i++) reg_write(8'h38, 14'(8'h40 + i));
        reg_read(8'h34, v); check("R12 tx full", v, 1);
        reg_write(8'h38, 14'h99);
        push_op(5'h08, 9'd16);
        wait_done();
        reg_read(8'h34, v); check("R12 tx not full", v, 0);
        check("R12 count", mosi_cap.size(), 16);
        for (int i = 0; i < 16; i++) check("R12 byte", mosi_cap[i], 8'h40 + i);
        reg_write(8'h38, 14'h77);
        push_op(5'h08, 9'd1);
        wait_done();
        check("R12 dropped byte absent", mosi_cap[16], 8'h77);

        // R4 chip select high
        push_op(5'h00, 9'd1);
        wait_done();
        check("R4 cs high", spi_cs_n, 1);
        check("R13 sck idle", spi_sck, 0);

        summary();
    end
endmodule